// File: doc/BRIEF.md
# Serial Bitstream Configuration Master

This block loads a configuration bitstream into a target device over a one-bit serial path. When `start` is pulsed, it runs the whole load sequence. It first holds the target's active-low program line low and waits for the target's active-low init line to fall. It then releases program and waits for init to come back high. Next it shifts the bitstream out, most significant bit first, on a divided configuration clock. Once the data is sent, it keeps clocking ones until the target reports done, then gives a fixed tail of extra clocks.

Bitstream bytes arrive on a valid/ready stream with a last flag. The block takes a new byte only after all eight bits of the previous byte have been clocked out. Before each byte it checks two conditions:
- If the target reports done, loading ends early.
- If the init line has dropped, the load is treated as a data-integrity failure and aborted.

All waits are bounded by timeouts expressed in system clock cycles. These are derived from the clock frequency parameter. When a run ends, `busy` falls and either `ok` or `err` is set with an error code. The status holds until the next start.

Top module: `cfg_serial_master`

## Requirements
- R1: After `start`, `cfg_prog_n` goes low and stays low for at least ceil(CLK_HZ·PROG_NS/1e9) cycles, and it is not released until `cfg_init_n` has been seen low. If `cfg_init_n` is not low within the init timeout, the run ends with `err_code` = 1 and `cfg_prog_n` high.
- R2: After program is released, no byte is accepted and no configuration clock edge is produced until `cfg_init_n` is high. If it stays low for the init timeout, the run ends with `err_code` = 2.
- R3: Each byte is sent bit 7 first, down to bit 0. Each bit occupies one rising edge of `cfg_cclk`.
- R4: `cfg_cclk` idles high. Each bit is a low half followed by a high half, each half being CLK_HZ/(2·CCLK_HZ) system cycles. `cfg_dout` does not change at a rising edge of `cfg_cclk`.
- R5: `s_ready` is high only while loading with no bit in flight. After a byte is taken, `s_ready` stays low until its eight bits are sent. Bytes offered while idle are not consumed.
- R6: If `cfg_done` is high when the next byte is due, no further bytes are taken and the completion phase starts.
- R7: If `cfg_init_n` is low when the next byte is due (and `cfg_done` is low), the run aborts with `err_code` = 3.
- R8: After the data, `cfg_dout` is held at 1 while `cfg_cclk` keeps pulsing. Once `cfg_done` and `cfg_init_n` are both high, exactly 8 more rising edges follow, then `ok` is set.
- R9: If the completion condition is not reached within the done timeout after the data ends, the run ends with `err_code` = 4.
- R10: While idle, `ok`, `err` and `err_code` (0 none, 1 init did not fall, 2 init did not rise, 3 init dropped during data, 4 done timeout) hold their values until the next `start`. A `start` while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a load sequence (sampled while idle) |
| s_data | input | 8 | Bitstream byte |
| s_valid | input | 1 | Byte available |
| s_last | input | 1 | Byte is the final one of the bitstream |
| s_ready | output | 1 | Byte accepted this cycle when high with `s_valid` |
| cfg_prog_n | output | 1 | Active-low program request to the target |
| cfg_init_n | input | 1 | Active-low init status from the target |
| cfg_done | input | 1 | Configuration complete from the target |
| cfg_cclk | output | 1 | Configuration clock, target samples on rising edge |
| cfg_dout | output | 1 | Serial configuration data |
| busy | output | 1 | Sequence in progress |
| ok | output | 1 | Last sequence succeeded |
| err | output | 1 | Last sequence failed |
| err_code | output | 3 | Failure reason, encoding in R10 |

## Verification
The embedded assertions check, on every cycle, the following rules:
- Data never moves at a rising configuration-clock edge.
- Program is released only once init has been seen low, or as part of an abort.
- No second byte is taken while a byte is in flight.
- The clock idles high.
- A low init at a byte boundary ends in error code 3.
- Status holds while idle.

Other behaviours can only be shown by the bench scenarios, where a reactive target model is scripted per run:
- the bit order against a scoreboard;
- the minimum program pulse width;
- the wait for init before the first bit;
- the early-done cut-off;
- the count of exactly eight tail edges;
- each timeout code.

// File: rtl/cfg_serial_master.sv
module cfg_serial_master #(
  parameter int CLK_HZ      = 100_000_000,
  parameter int CCLK_HZ     = 25_000_000,
  parameter int PROG_NS     = 300,
  parameter int INIT_TMO_US = 500_000,
  parameter int DONE_TMO_US = 200_000,
  parameter int TAIL_CYC    = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] s_data,
  input  logic       s_valid,
  input  logic       s_last,
  output logic       s_ready,
  output logic       cfg_prog_n,
  input  logic       cfg_init_n,
  input  logic       cfg_done,
  output logic       cfg_cclk,
  output logic       cfg_dout,
  output logic       busy,
  output logic       ok,
  output logic       err,
  output logic [2:0] err_code
);
  localparam int HALF_RAW = CLK_HZ / (2 * CCLK_HZ);
  localparam int HALF     = (HALF_RAW < 1) ? 1 : HALF_RAW;
  localparam int PROG_CYC = ((CLK_HZ / 1000) * PROG_NS + 999_999) / 1_000_000;
  localparam int INIT_CYC = (CLK_HZ / 1_000_000) * INIT_TMO_US;
  localparam int DONE_CYC = (CLK_HZ / 1_000_000) * DONE_TMO_US;
  localparam int TMAX     = (INIT_CYC > DONE_CYC) ? INIT_CYC : DONE_CYC;
  localparam int TW       = $clog2(TMAX + 1);
  localparam int HW       = $clog2(HALF + 1);
  localparam int XW       = $clog2(TAIL_CYC + 1);

  localparam logic [2:0] E_NONE   = 3'd0;
  localparam logic [2:0] E_NOFALL = 3'd1;
  localparam logic [2:0] E_NORISE = 3'd2;
  localparam logic [2:0] E_CRC    = 3'd3;
  localparam logic [2:0] E_NODONE = 3'd4;

  typedef enum logic [2:0] {S_IDLE, S_PROG, S_WINIT, S_LOAD, S_FLUSH} state_t;

  state_t          st;
  logic [TW-1:0]   tmr;
  logic [HW-1:0]   hc;
  logic            lo, lastb, seen, prog_r, ok_r, err_r;
  logic [7:0]      sh;
  logic [3:0]      bc;
  logic [XW-1:0]   ext;
  logic [2:0]      code_r;

  wire half_end = (hc == HW'(HALF - 1));
  wire slot_end = half_end && !lo;
  wire fin      = slot_end && seen && (ext == XW'(TAIL_CYC - 1));

  assign cfg_cclk   = !lo;
  assign cfg_prog_n = prog_r;
  assign cfg_dout   = (st == S_FLUSH) ? 1'b1 : sh[7];
  assign s_ready    = (st == S_LOAD) && (bc == 4'd0) && !cfg_done && cfg_init_n;
  assign busy       = (st != S_IDLE);
  assign ok         = ok_r;
  assign err        = err_r;
  assign err_code   = code_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; tmr <= '0; hc <= '0; lo <= 1'b0; sh <= 8'hFF; bc <= 4'd0;
      lastb <= 1'b0; seen <= 1'b0; ext <= '0; prog_r <= 1'b1;
      ok_r <= 1'b0; err_r <= 1'b0; code_r <= E_NONE;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st <= S_PROG; prog_r <= 1'b0; tmr <= '0; sh <= 8'hFF;
          ok_r <= 1'b0; err_r <= 1'b0; code_r <= E_NONE;
        end
        S_PROG: begin
          tmr <= tmr + 1'b1;
          if (tmr >= TW'(PROG_CYC - 1) && !cfg_init_n) begin
            st <= S_WINIT; prog_r <= 1'b1; tmr <= '0;
          end else if (tmr == TW'(INIT_CYC - 1)) begin
            st <= S_IDLE; prog_r <= 1'b1; err_r <= 1'b1; code_r <= E_NOFALL;
          end
        end
        S_WINIT: begin
          tmr <= tmr + 1'b1;
          if (cfg_init_n) begin
            st <= S_LOAD; bc <= 4'd0; hc <= '0;
          end else if (tmr == TW'(INIT_CYC - 1)) begin
            st <= S_IDLE; err_r <= 1'b1; code_r <= E_NORISE;
          end
        end
        S_LOAD: begin
          if (bc == 4'd0) begin
            if (cfg_done) begin
              st <= S_FLUSH; seen <= cfg_init_n; ext <= '0; tmr <= '0; lo <= 1'b1; hc <= '0;
            end else if (!cfg_init_n) begin
              st <= S_IDLE; err_r <= 1'b1; code_r <= E_CRC;
            end else if (s_valid) begin
              sh <= s_data; bc <= 4'd8; lastb <= s_last; lo <= 1'b1; hc <= '0;
            end
          end else if (!half_end) begin
            hc <= hc + 1'b1;
          end else begin
            hc <= '0;
            if (lo) lo <= 1'b0;
            else begin
              sh <= {sh[6:0], 1'b1};
              bc <= bc - 4'd1;
              if (bc != 4'd1) lo <= 1'b1;
              else if (lastb) begin
                st <= S_FLUSH; seen <= cfg_done && cfg_init_n; ext <= '0; tmr <= '0; lo <= 1'b1;
              end
            end
          end
        end
        S_FLUSH: begin
          tmr <= tmr + 1'b1;
          if (!half_end) hc <= hc + 1'b1;
          else begin
            hc <= '0;
            if (lo) lo <= 1'b0;
            else if (fin) begin
              st <= S_IDLE; ok_r <= 1'b1;
            end else begin
              lo <= 1'b1;
              if (seen) ext <= ext + 1'b1;
              else seen <= cfg_done && cfg_init_n;
            end
          end
          if (tmr == TW'(DONE_CYC - 1) && !fin) begin
            st <= S_IDLE; lo <= 1'b0; err_r <= 1'b1; code_r <= E_NODONE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_dout_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_cclk) |-> $stable(cfg_dout));

  assert_cclk_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cfg_cclk);

  assert_prog_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_prog_n) |-> (!$past(cfg_init_n) || err));

  assert_one_in_flight_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> !s_ready);

  assert_crc_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LOAD && bc == 4'd0 && !cfg_init_n && !cfg_done) |=> (err && err_code == E_CRC));

  assert_status_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable({ok, err, err_code}));
endmodule

// File: tb/tb_cfg_serial_master.sv
module tb_cfg_serial_master;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [7:0] s_data;
  logic s_valid, s_last, s_ready;
  logic cfg_prog_n, cfg_init_n, cfg_done, cfg_cclk, cfg_dout;
  logic busy, ok, err;
  logic [2:0] err_code;

  always #5 clk = ~clk;

  cfg_serial_master #(.CLK_HZ(100_000_000), .CCLK_HZ(25_000_000), .PROG_NS(300),
                      .INIT_TMO_US(3), .DONE_TMO_US(5), .TAIL_CYC(8)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .s_data(s_data), .s_valid(s_valid),
    .s_last(s_last), .s_ready(s_ready), .cfg_prog_n(cfg_prog_n), .cfg_init_n(cfg_init_n),
    .cfg_done(cfg_done), .cfg_cclk(cfg_cclk), .cfg_dout(cfg_dout), .busy(busy),
    .ok(ok), .err(err), .err_code(err_code));

  int checks = 0, fails = 0, cyc = 0;
  logic clr = 1'b0, src_on = 1'b0;

  task automatic chk(input bit c, input string req, input string what, input int act, input int exp);
    checks++;
    if (!c) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // byte source
  logic [7:0] src_mem [16];
  int src_n = 0, src_idx = 0;
  assign s_valid = src_on && (src_idx < src_n);
  assign s_data  = (src_idx < src_n) ? src_mem[src_idx[3:0]] : 8'h00;
  assign s_last  = (src_idx == src_n - 1);
  always @(posedge clk)
    if (clr) src_idx <= 0;
    else if (s_valid && s_ready) src_idx <= src_idx + 1;

  // reactive target model
  int m_fall = 3, m_rise = 40, m_done = -1, m_crc = -1;
  int lowcnt = 0, hicnt = 0, edges = 0;
  logic armed = 1'b0, mcclk_q = 1'b1;
  initial begin cfg_init_n = 1'b1; cfg_done = 1'b0; end
  always @(posedge clk) begin
    mcclk_q <= cfg_cclk;
    if (clr) begin
      cfg_init_n <= 1'b1; cfg_done <= 1'b0; armed <= 1'b0; lowcnt <= 0; hicnt <= 0; edges <= 0;
    end else if (!cfg_prog_n) begin
      lowcnt <= lowcnt + 1; armed <= 1'b1; hicnt <= 0; edges <= 0; cfg_done <= 1'b0;
      if (lowcnt == m_fall) cfg_init_n <= 1'b0;
    end else begin
      lowcnt <= 0;
      if (armed) begin
        hicnt <= hicnt + 1;
        if (hicnt == m_rise) begin cfg_init_n <= 1'b1; armed <= 1'b0; end
      end
      if (cfg_cclk && !mcclk_q) begin
        edges <= edges + 1;
        if (edges + 1 == m_done) cfg_done <= 1'b1;
        if (edges + 1 == m_crc) cfg_init_n <= 1'b0;
      end
    end
  end

  // scoreboard monitor
  bit expq[$];
  int rises = 0, tail = 0, t_rel = -1, t_first = -1, r1 = -1, r2 = -1, plow = 0;
  logic prog_q = 1'b1, cclk_q = 1'b1;
  always @(negedge clk) begin
    if (clr) begin
      rises = 0; tail = 0; t_rel = -1; t_first = -1; r1 = -1; r2 = -1; plow = 0;
    end else if (rst_n) begin
      if (!cfg_prog_n) plow++;
      if (cfg_prog_n && !prog_q) t_rel = cyc;
      if (!cfg_cclk && cclk_q && t_first < 0) t_first = cyc;
      if (cfg_cclk && !cclk_q) begin
        rises++;
        if (r1 < 0) r1 = cyc; else if (r2 < 0) r2 = cyc;
        if (expq.size() > 0) begin
          bit b;
          b = expq.pop_front();
          chk(cfg_dout === b, "R3", "data bit", int'(cfg_dout), int'(b));
        end else begin
          chk(cfg_dout === 1'b1, "R8", "flush data", int'(cfg_dout), 1);
          if (cfg_done) tail++;
        end
      end
    end
    prog_q = cfg_prog_n;
    cclk_q = cfg_cclk;
  end

  task automatic run(input int nb, input int fall, input int rise, input int dedge,
                     input int cedge, input int nexp, input bit poke, input int seed);
    @(negedge clk);
    clr <= 1'b1; src_on <= 1'b1;
    m_fall <= fall; m_rise <= rise; m_done <= dedge; m_crc <= cedge; src_n <= nb;
    expq.delete();
    for (int i = 0; i < nb; i++) begin
      logic [7:0] v;
      v = 8'h5A ^ 8'(i * 37 + seed);
      src_mem[i] <= v;
      if (i < nexp) for (int j = 7; j >= 0; j--) expq.push_back(v[j]);
    end
    @(negedge clk);
    clr <= 1'b0; start <= 1'b1;
    @(negedge clk);
    start <= 1'b0;
    for (int k = 0; k < 6000; k++) begin
      @(negedge clk);
      start <= (poke && k == 100);
      if (!busy && k > 0) break;
      if (k == 5999) chk(1'b0, "R10", "run did not end", 1, 0);
    end
    start <= 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R10", "watchdog expired", 1, 0);
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(!busy && cfg_prog_n && cfg_cclk, "R4", "reset lines idle", int'({busy, cfg_prog_n, cfg_cclk}), 3);
    chk(!s_ready, "R5", "reset ready", int'(s_ready), 0);
    chk(!ok && !err && err_code == 3'd0, "R10", "reset status", int'({ok, err, err_code}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // normal load, with a stray start while busy
    run(4, 3, 40, 35, -1, 4, 1'b1, 0);
    chk(ok && !err && err_code == 3'd0, "R8", "normal ok", int'({ok, err, err_code}), 16);
    chk(src_idx == 4, "R10", "stray start ignored, bytes used", src_idx, 4);
    chk(plow >= 30, "R1", "prog pulse cycles", plow, 30);
    chk(t_first - t_rel > 40, "R2", "cycles release to first bit", t_first - t_rel, 41);
    chk(r2 - r1 == 4, "R4", "bit period", r2 - r1, 4);
    chk(tail == 8, "R8", "tail edges", tail, 8);
    chk(expq.size() == 0, "R3", "bits left", expq.size(), 0);

    // init falls late, done at last bit
    run(2, 50, 10, 16, -1, 2, 1'b0, 7);
    chk(plow > 50, "R1", "prog held until init low", plow, 51);
    chk(ok && err_code == 3'd0, "R8", "late init ok", int'({ok, err_code}), 8);
    chk(tail == 8, "R8", "tail edges at last bit", tail, 8);

    // idle hold: offered bytes not consumed, status kept
    @(negedge clk);
    clr <= 1'b1; src_n <= 3;
    @(negedge clk);
    clr <= 1'b0;
    repeat (50) begin
      @(negedge clk);
      if (s_ready) chk(1'b0, "R5", "ready while idle", 1, 0);
    end
    chk(src_idx == 0, "R5", "idle bytes consumed", src_idx, 0);
    chk(ok && !err, "R10", "status held idle", int'({ok, err}), 2);

    // early done
    run(4, 3, 20, 12, -1, 2, 1'b0, 3);
    chk(src_idx == 2, "R6", "bytes taken before done", src_idx, 2);
    chk(ok && tail == 8, "R6", "early done tail", tail, 8);

    // init drops mid-stream
    run(3, 3, 20, -1, 10, 2, 1'b0, 9);
    chk(err && !ok && err_code == 3'd3, "R7", "crc code", int'(err_code), 3);
    chk(src_idx == 2 && tail == 0, "R7", "bytes before abort", src_idx, 2);

    // init never falls
    run(2, -1, 20, -1, -1, 0, 1'b0, 1);
    chk(err && err_code == 3'd1 && cfg_prog_n, "R1", "no-fall code", int'(err_code), 1);
    chk(rises == 0, "R1", "edges after no-fall", rises, 0);

    // init never rises
    run(2, 3, -1, -1, -1, 0, 1'b0, 2);
    chk(err && err_code == 3'd2, "R2", "no-rise code", int'(err_code), 2);
    chk(rises == 0 && src_idx == 0, "R2", "edges before init high", rises, 0);

    // done never comes
    run(2, 3, 10, -1, -1, 2, 1'b0, 5);
    chk(err && err_code == 3'd4, "R9", "done timeout code", int'(err_code), 4);
    chk(src_idx == 2, "R9", "all bytes sent", src_idx, 2);
    repeat (20) @(negedge clk);
    chk(err && err_code == 3'd4 && !busy, "R10", "error status held", int'(err_code), 4);

    summary();
    $finish;
  end
endmodule